// File: doc/BRIEF.md
# PWM Output Steering Unit

This block produces one pulse-width waveform from an 8-bit period and duty pair and routes it to any mix of four pins, A to D. A pin whose enable is clear passes its general-purpose port-data bit through unchanged. A steered pin carries the waveform. A per-pin polarity set by two mode bits is applied to that waveform.

Software reaches four registers through a simple write port and a combinational read port. Enable changes can apply on the next clock edge. They can also be parked in a shadow register and loaded at the next period start, so a pin never sees a cut-off pulse.

An external shutdown input drives every steered pin to its idle level at once. Unsteered pins are untouched. After shutdown drops, the steered pins stay idle until a new period begins.

Two state machines carry the control.

The enable-sync machine has two states:
- `SY_IDLE`: no enable value is waiting.
- `SY_PEND`: a shadow value is waiting for the period start.

Its transitions are:
- Idle to pending on a steering write with sync=1.
- Pending to pending on another sync write, which replaces the waiting value.
- Pending to idle on a sync=0 write.
- Pending to idle on a period end with no steering write, which loads the shadow value.

The shutdown machine has three states: `SD_RUN`, `SD_HOLD` and `SD_WAIT`. Its transitions are:
- Run to hold when shutdown is seen.
- Hold to wait when shutdown drops.
- Wait to hold on a new shutdown.
- Wait to run on a period end.

Top module: `pwm_steer`

## Requirements
- R1: After reset the steering register reads 0x01 and the mode register reads 0x0C. Only pin A carries the waveform; pins B to D show port data.
- R2: Steering bit i (bit 0 = pin A, bit 1 = B, bit 2 = C, bit 3 = D) selects the waveform when set and port data when clear. Any combination of pins may carry the waveform at once.
- R3: A steering write (address 0) with bit 4 = 0 changes the active enables on the clock edge that takes the write. Pins show the new routing from the next cycle.
- R4: A steering write with bit 4 = 1 leaves the active enables unchanged. The value loads on the first period end with no steering write on that edge. A later sync write before that point replaces the waiting value.
- R5: Steering applies only when mode bits [3:2] = 11 and configuration bits [7:6] of the mode register (address 1) = 00. Otherwise all four pins show port data.
- R6: Mode bits [1:0] set the polarity:
  - 00: all pins active-high.
  - 01: A and C active-high; B and D active-low.
  - 10: A and C active-low; B and D active-high.
  - 11: all pins active-low.
  An active-low pin carries the inverted waveform.
- R7: While shutdown is high, every steered pin shows its inactive level (1 for an active-low pin, 0 for an active-high pin) in the same cycle. Unsteered pins keep showing port data.
- R8: After shutdown falls, steered pins stay at the inactive level up to and including the next period-end cycle. They resume the waveform when the counter restarts at 0.
- R9: The counter runs from 0 up to the period value (address 2), then wraps to 0. period_end is high in the cycle the counter is at or above the period. The waveform is high while the counter is below the duty value (address 3).
- R10: Reads are combinational. Steering register bits [7:5] and mode register bits [5:4] read 0. Period and duty read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 steering, 1 mode, 2 period, 3 duty |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| shutdown | input | 1 | Forces steered pins to their inactive level |
| port_data | input | 4 | General-purpose data for pins A..D |
| pins | output | 4 | Pin outputs, bit 0 = A |
| period_end | output | 1 | High in the last cycle of each period |

## Verification
The following results appear in the same cycle as the inputs that cause them:
- the pin values;
- the shutdown forcing;
- the read data.

A register write shows at the outputs one cycle after the edge that takes it. A shadow enable value shows in the cycle after the period-end edge, which is the cycle the counter reads 0. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a cycle model that advances on each rising edge. Every comparison therefore falls in the cycle the requirement names.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    localparam int REG_W  = 8;
    localparam int N_PINS = 4;

    localparam logic [1:0] ADDR_STEER = 2'd0;
    localparam logic [1:0] ADDR_MODE  = 2'd1;
    localparam logic [1:0] ADDR_PER   = 2'd2;
    localparam logic [1:0] ADDR_DUTY  = 2'd3;

    typedef enum logic [0:0] {
        SY_IDLE,
        SY_PEND
    } sync_st_t;

    typedef enum logic [1:0] {
        SD_RUN,
        SD_HOLD,
        SD_WAIT
    } sd_st_t;

endpackage

// File: rtl/pwm_steer_gen.sv
module pwm_steer_gen #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] period,
    input  logic [DW-1:0] duty,
    output logic          pwm,
    output logic          period_end
);

    logic [DW-1:0] cnt_q;

    // Wrap on >= so a period written below the running count ends at once.
    assign period_end = (cnt_q >= period);
    assign pwm        = (cnt_q < duty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
    import pwm_steer_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_PERIOD = 8'hFF,
    parameter logic [REG_W-1:0] RST_DUTY   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              period_end,
    output logic [N_PINS-1:0] en_act,
    output logic [3:0]        mode_q,
    output logic [1:0]        cfg_q,
    output logic [REG_W-1:0]  per_q,
    output logic [REG_W-1:0]  duty_q
);

    localparam int SYNC_BIT = N_PINS;

    sync_st_t          st_q, st_nx;
    logic              sync_q;
    logic [N_PINS-1:0] en_wr_q;
    logic [N_PINS-1:0] shadow_q;
    logic              steer_wr;
    logic              wr_sync;

    assign steer_wr = wr_en && (wr_addr == ADDR_STEER);
    assign wr_sync  = wr_data[SYNC_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SY_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            SY_IDLE: begin
                if (steer_wr && wr_sync) st_nx = SY_PEND;
            end
            SY_PEND: begin
                if (steer_wr)        st_nx = wr_sync ? SY_PEND : SY_IDLE;
                else if (period_end) st_nx = SY_IDLE;
            end
            default: st_nx = SY_IDLE;
        endcase
    end

    // enable datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_act   <= N_PINS'(1);
            en_wr_q  <= N_PINS'(1);
            shadow_q <= '0;
            sync_q   <= 1'b0;
        end else if (steer_wr) begin
            sync_q  <= wr_sync;
            en_wr_q <= wr_data[N_PINS-1:0];
            if (wr_sync) shadow_q <= wr_data[N_PINS-1:0];
            else         en_act   <= wr_data[N_PINS-1:0];
        end else if (st_q == SY_PEND && period_end) begin
            en_act <= shadow_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 4'b1100;
            cfg_q  <= 2'b00;
            per_q  <= RST_PERIOD;
            duty_q <= RST_DUTY;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_STEER: ;
                ADDR_MODE: begin
                    mode_q <= wr_data[3:0];
                    cfg_q  <= wr_data[7:6];
                end
                ADDR_PER:  per_q  <= wr_data;
                ADDR_DUTY: duty_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_STEER: rd_data = {3'b000, sync_q, en_wr_q};
            ADDR_MODE:  rd_data = {cfg_q, 2'b00, mode_q};
            ADDR_PER:   rd_data = per_q;
            ADDR_DUTY:  rd_data = duty_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pwm_steer_pinmux.sv
module pwm_steer_pinmux
    import pwm_steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shutdown,
    input  logic              period_end,
    input  logic              pwm,
    input  logic              steer_on,
    input  logic [N_PINS-1:0] en_act,
    input  logic [1:0]        pol,
    input  logic [N_PINS-1:0] port_data,
    output logic [N_PINS-1:0] pins
);

    sd_st_t sd_q, sd_nx;
    logic   force_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sd_q <= SD_RUN;
        else        sd_q <= sd_nx;
    end

    always_comb begin
        sd_nx = sd_q;
        unique case (sd_q)
            SD_RUN:  if (shutdown) sd_nx = SD_HOLD;
            SD_HOLD: if (!shutdown) sd_nx = SD_WAIT;
            SD_WAIT: begin
                if (shutdown)        sd_nx = SD_HOLD;
                else if (period_end) sd_nx = SD_RUN;
            end
            default: sd_nx = SD_RUN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (sd_q)
            SD_RUN:  force_idle = shutdown;
            SD_HOLD: force_idle = 1'b1;
            SD_WAIT: force_idle = 1'b1;
            default: force_idle = 1'b1;
        endcase
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // odd pins follow pol[0], even pins follow pol[1]
        logic inv;
        assign inv     = (i % 2 == 1) ? pol[0] : pol[1];
        assign pins[i] = (steer_on && en_act[i]) ? (force_idle ? inv : (pwm ^ inv))
                                                 : port_data[i];
    end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
    import pwm_steer_pkg::*;
#(
    parameter logic [REG_W-1:0] RST_PERIOD = 8'hFF,
    parameter logic [REG_W-1:0] RST_DUTY   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              shutdown,
    input  logic [N_PINS-1:0] port_data,
    output logic [N_PINS-1:0] pins,
    output logic              period_end
);

    logic [N_PINS-1:0] en_act;
    logic [3:0]        mode_q;
    logic [1:0]        cfg_q;
    logic [REG_W-1:0]  per_q;
    logic [REG_W-1:0]  duty_q;
    logic              pwm;
    logic              steer_on;

    assign steer_on = (mode_q[3:2] == 2'b11) && (cfg_q == 2'b00);

    pwm_steer_regs #(
        .RST_PERIOD (RST_PERIOD),
        .RST_DUTY   (RST_DUTY)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .period_end (period_end),
        .en_act     (en_act),
        .mode_q     (mode_q),
        .cfg_q      (cfg_q),
        .per_q      (per_q),
        .duty_q     (duty_q)
    );

    pwm_steer_gen #(
        .DW (REG_W)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .period     (per_q),
        .duty       (duty_q),
        .pwm        (pwm),
        .period_end (period_end)
    );

    pwm_steer_pinmux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .shutdown   (shutdown),
        .period_end (period_end),
        .pwm        (pwm),
        .steer_on   (steer_on),
        .en_act     (en_act),
        .pol        (mode_q[1:0]),
        .port_data  (port_data),
        .pins       (pins)
    );

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [1:0] rd_addr,
    input logic [7:0] rd_data,
    input logic       shutdown,
    input logic [3:0] port_data,
    input logic [3:0] pins,
    input logic       period_end,
    input logic [3:0] en_act,
    input logic [3:0] mode_q,
    input logic [1:0] cfg_q,
    input logic [7:0] per_q
);

    logic       ok_mode;
    logic [3:0] eff;
    logic [3:0] idle_lvl;

    assign ok_mode  = (mode_q[3:2] == 2'b11) && (cfg_q == 2'b00);
    assign eff      = ok_mode ? en_act : 4'b0000;
    assign idle_lvl = {mode_q[0], mode_q[1], mode_q[0], mode_q[1]};

    AST_OFF_MODE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_mode |-> (pins == port_data));                                   // R5

    AST_SD_STEERED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (((pins ^ idle_lvl) & eff) == 4'b0000));               // R7

    AST_SD_UNSTEERED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (((pins ^ port_data) & ~eff) == 4'b0000));             // R7

    AST_SD_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(shutdown) && $past(rst_n)) |-> (((pins ^ idle_lvl) & eff) == 4'b0000)); // R8

    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && !wr_data[4]) |=> (en_act == $past(wr_data[3:0]))); // R3

    AST_SYNC_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && wr_data[4]) |=> $stable(en_act));      // R4

    AST_WRAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (!period_end || per_q == 8'd0));                     // R9

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd0) |-> (rd_data[7:5] == 3'b000));                    // R10

endmodule

bind pwm_steer pwm_steer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .shutdown   (shutdown),
    .port_data  (port_data),
    .pins       (pins),
    .period_end (period_end),
    .en_act     (en_act),
    .mode_q     (mode_q),
    .cfg_q      (cfg_q),
    .per_q      (per_q)
);

// File: tb/test_pwm_steer.sv
`timescale 1ns/1ps
module test_pwm_steer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       shutdown = 1'b0;
    logic [3:0] port_data = 4'd0;
    logic [3:0] pins;
    logic       period_end;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_steer i_pwm_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .shutdown   (shutdown),
        .port_data  (port_data),
        .pins       (pins),
        .period_end (period_end)
    );

    // cycle model built from the requirements
    logic [7:0] m_cnt, m_per, m_duty;
    logic [3:0] m_mode, m_en_reg, m_act, m_shadow;
    logic [1:0] m_cfg;
    logic       m_sync, m_pend;
    int         m_sd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 8'hFF; m_duty = 8'h80;
            m_mode = 4'hC; m_cfg = 0; m_sync = 0;
            m_en_reg = 4'h1; m_act = 4'h1; m_shadow = 0; m_pend = 0; m_sd = 0;
        end else begin
            logic pe;
            pe = (m_cnt >= m_per);
            case (m_sd)
                0: if (shutdown) m_sd = 1;
                1: if (!shutdown) m_sd = 2;
                default: if (shutdown) m_sd = 1; else if (pe) m_sd = 0;
            endcase
            if (wr_en && wr_addr == 2'd0) begin
                m_sync = wr_data[4];
                m_en_reg = wr_data[3:0];
                if (wr_data[4]) begin m_shadow = wr_data[3:0]; m_pend = 1; end
                else begin m_act = wr_data[3:0]; m_pend = 0; end
            end else if (m_pend && pe) begin
                m_act = m_shadow; m_pend = 0;
            end
            if (wr_en && wr_addr == 2'd1) begin m_mode = wr_data[3:0]; m_cfg = wr_data[7:6]; end
            if (wr_en && wr_addr == 2'd2) m_per = wr_data;
            if (wr_en && wr_addr == 2'd3) m_duty = wr_data;
            m_cnt = pe ? 8'd0 : m_cnt + 8'd1;
        end
    end

    function automatic logic [3:0] exp_pins();
        logic [3:0] r;
        logic [3:0] inv;
        logic on, frc, w;
        on  = (m_mode[3:2] == 2'b11) && (m_cfg == 2'b00);
        inv = {m_mode[0], m_mode[1], m_mode[0], m_mode[1]};
        w   = (m_cnt < m_duty);
        frc = shutdown || (m_sd != 0);
        for (int i = 0; i < 4; i++)
            r[i] = (on && m_act[i]) ? (frc ? inv[i] : (w ^ inv[i])) : port_data[i];
        return r;
    endfunction

    function automatic logic [7:0] exp_rd();
        case (rd_addr)
            2'd0: return {3'b000, m_sync, m_en_reg};
            2'd1: return {m_cfg, 2'b00, m_mode};
            2'd2: return m_per;
            default: return m_duty;
        endcase
    endfunction

    task automatic lit(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare all outputs 1 ns after the falling edge, then advance
    task automatic check_all(input string tag);
        #1;
        checks++;
        if (pins !== exp_pins() || period_end !== (m_cnt >= m_per) || rd_data !== exp_rd()) begin
            failures++;
            $display("FAIL %s actual pins=%b pe=%b rd=%h expected pins=%b pe=%b rd=%h",
                     tag, pins, period_end, rd_data, exp_pins(), (m_cnt >= m_per), exp_rd());
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        check_all(tag);
        wr_en = 1'b0;
    endtask

    task automatic wait_pe(input string tag);
        for (int k = 0; k < 300; k++) begin
            #1;
            if (period_end) break;
            check_all(tag);
        end
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        port_data = 4'b1010;
        rd_addr = 2'd0; #1; lit("R1 steer reset", rd_data, 8'h01);
        rd_addr = 2'd1; #1; lit("R1 mode reset", rd_data, 8'h0C);
        lit("R1 pins after reset", {4'h0, pins}, 8'h0B);
        check_all("R1");

        // R9 period and duty literal
        wr(2'd2, 8'd9, "R9 write period");
        wr(2'd3, 8'd4, "R9 write duty");
        rd_addr = 2'd2; #1; lit("R10 period readback", rd_data, 8'd9);
        port_data = 4'b0000;
        wait_pe("R9 sync");
        for (int k = 0; k < 10; k++) begin
            #1;
            lit("R9 waveform", {7'd0, pins[0]}, {7'd0, (k < 4)});
            lit("R9 period_end", {7'd0, period_end}, {7'd0, (k == 9)});
            @(negedge clk);
        end

        // R2 combinations, immediate (R3)
        rd_addr = 2'd0;
        for (int c = 0; c < 16; c++) begin
            port_data = 4'(c * 7);
            wr(2'd0, 8'(c), "R3 immediate write");
            #1; lit("R3 routing next cycle", {4'h0, pins & ~4'(c)}, {4'h0, port_data & ~4'(c)});
            check_all("R2 combination");
            check_all("R2 combination");
        end

        // R4 deferred load with replacement
        wr(2'd0, 8'h01, "R4 setup");
        port_data = 4'b0000;
        wait_pe("R4 align");
        wr(2'd0, 8'h1F, "R4 sync write");
        check_all("R4 pending");
        wr(2'd0, 8'h16, "R4 replace");
        #1; lit("R4 held pin B", {7'd0, pins[1]}, 8'd0);
        wait_pe("R4 wait");
        #1; lit("R4 loaded pin B", {7'd0, pins[1]}, 8'd1);
        lit("R4 pin A port", {7'd0, pins[0]}, 8'd0);
        check_all("R4 loaded");

        // R5 mode gating
        wr(2'd0, 8'h0F, "R5 all on");
        port_data = 4'b0110;
        wr(2'd1, 8'h08, "R5 non-pwm mode");
        #1; lit("R5 mode off", {4'h0, pins}, 8'h06);
        wr(2'd1, 8'h4C, "R5 cfg not single");
        #1; lit("R5 cfg off", {4'h0, pins}, 8'h06);
        rd_addr = 2'd1; #1; lit("R10 mode readback", rd_data, 8'h4C);

        // R6 polarity
        for (int p = 0; p < 4; p++) begin
            wr(2'd1, 8'(8'h0C | p), "R6 polarity");
            for (int k = 0; k < 12; k++) check_all("R6 polarity");
        end

        // R7 / R8 shutdown
        wr(2'd1, 8'h0D, "R7 mode 01");
        wr(2'd0, 8'h05, "R7 A and C");
        port_data = 4'b1010;
        shutdown = 1'b1;
        #1; lit("R7 forced", {4'h0, pins}, 8'h0A);
        for (int k = 0; k < 5; k++) check_all("R7 shutdown");
        shutdown = 1'b0;
        #1; lit("R8 still idle", {4'h0, pins}, 8'h0A);
        wait_pe("R8 wait");
        for (int k = 0; k < 6; k++) check_all("R8 resume");

        // R10 reserved bits
        wr(2'd0, 8'hFF, "R10 write ones");
        rd_addr = 2'd0; #1; lit("R10 reserved zero", rd_data, 8'h1F);

        // constrained random
        void'($urandom(32'd4242));
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            port_data = r[3:0];
            rd_addr = r[5:4];
            if (r[12:10] == 3'd0) shutdown = ~shutdown;
            if (r[8:6] == 3'd0) begin
                wr_en = 1'b1; wr_addr = r[14:13];
                case (r[14:13])
                    2'd0: wr_data = {3'b000, r[20:16]};
                    2'd1: wr_data = (r[22:21] == 0) ? r[31:24] : {2'b00, 2'b00, 2'b11, r[25:24]};
                    2'd2: wr_data = 8'(r[19:16]);
                    default: wr_data = 8'(r[20:16]);
                endcase
            end
            check_all("R2 R4 R6 R7 R8 random");
            wr_en = 1'b0;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule